// File: doc/BRIEF.md
# Delayed Configuration Write Target with Data Parity Handling

This block is the target-side controller for inbound configuration writes on a conventional parallel PCI bus, when those writes are handled as delayed transactions. It watches one address phase and one data phase for each transaction. It checks the data phase against the even parity bit that the master drives one clock later, and only then answers with a retry (STOP#) or with a disconnect-with-data (TRDY#). A single-entry delayed-write queue holds an accepted write for the internal side. The internal side pulls the entry out through a valid/ready request stream and pushes a completion status back through a valid/ready completion stream. The master then retries the same write to collect that status.

The reaction to a data parity error depends on the parity-error-response enable. With the enable set, the controller disconnects with data and raises PERR# for one clock, two clocks after TRDY#. The write is never enqueued, and an entry already waiting stays in the queue. With the enable clear, the error does not change the bus response. In every case a sticky detected-parity-error status bit is set. An interrupt status bit is also set unless the interrupt mask is set. Both bits are cleared by write-one-to-clear pulses.

Back-pressure on the internal side works as follows. `req_valid` stays high and the request fields stay constant until a cycle in which `req_ready` is also high. `cpl_ready` is high only while a delivered entry waits for its status, and a completion is taken in a cycle with `cpl_valid` and `cpl_ready` both high. The address-phase parity is not checked.

Top module: `dwpe_top`

## Requirements
- R1: Transaction timing is fixed. The address phase comes in cycle t0 (`addr_phase`=1, command on `cbe`). The data phase comes in t1 (`data_phase`=1, data on `ad`, byte enables on `cbe`). The data parity bit comes on `par` in t2. Exactly one of `trdy_n` or `stop_n` goes low, for one cycle, in t3. Neither is low in any earlier cycle, and both are high after reset.
- R2: A data parity error is detected when `par` in t2 differs from the XOR of the 32 data bits and 4 byte-enable bits of t1 (even parity). Correct parity causes no error indication.
- R3: On a parity error with `perr_resp_en`=1, the response is `trdy_n` low in t3 and `perr_n` low in t5 only. An empty queue stays empty (`req_valid` stays 0).
- R4: When the queue is empty, a configuration write that is not answered as in R3 is retried with `stop_n` and enqueued. `req_valid` is high from t3, with the write's address, data and byte enables. `perr_n` stays high.
- R5: Any detected data parity error sets `dpe_sts`. It stays set until a `clr_dpe` pulse.
- R6: A detected data parity error sets `irq_sts` when `irq_mask`=0 and leaves it unchanged when `irq_mask`=1. `irq_sts` stays set until a `clr_irq` pulse.
- R7: `req_valid` holds with stable fields until it is accepted. After acceptance `req_valid` is 0 and `cpl_ready` is 1, until a completion is accepted. Then `cpl_ready` is 0.
- R8: A retry whose address, data and byte enables match the queued entry, arriving before its completion is accepted, gets `stop_n`. The entry is kept.
- R9: A matching retry after the completion, with good parity or with `perr_resp_en`=0, gets `trdy_n`. `rsp_err` in t3 equals the accepted `cpl_err`, and the entry is freed.
- R10: A matching retry with a parity error and `perr_resp_en`=1 is answered as in R3. The entry is kept, and a later good retry completes it.
- R11: A configuration write that does not match an occupied entry, and is not answered as in R3, gets `stop_n` and is not queued.
- R12: An address phase whose command is not configuration write (4'b1011) gets no response. The queue and the status bits do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| perr_resp_en | input | 1 | Parity error response enable |
| irq_mask | input | 1 | Masks the interrupt status bit when 1 |
| addr_phase | input | 1 | Address phase strobe |
| data_phase | input | 1 | Data phase strobe |
| ad | input | DW | Address/data bus |
| cbe | input | BW | Command (address phase) or byte enables (data phase) |
| par | input | 1 | Even parity bit, one clock after the phase it covers |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop (retry), active low |
| perr_n | output | 1 | Data parity error, active low |
| rsp_err | output | 1 | Completion status returned with TRDY# |
| req_valid | output | 1 | Queued write available to internal side |
| req_ready | input | 1 | Internal side accepts the write |
| req_addr | output | DW | Queued address |
| req_data | output | DW | Queued data |
| req_be | output | BW | Queued byte enables |
| cpl_valid | input | 1 | Completion status valid |
| cpl_ready | output | 1 | Controller waits for completion |
| cpl_err | input | 1 | Completion status (1 = error) |
| dpe_sts | output | 1 | Sticky detected parity error |
| irq_sts | output | 1 | Sticky interrupt status |
| clr_dpe | input | 1 | Write-one-to-clear for dpe_sts |
| clr_irq | input | 1 | Write-one-to-clear for irq_sts |

## Verification
A queue stuck in the wrong state shows at the ports within one transaction. A matching retry gets the wrong handshake in t3, `req_valid` or `cpl_ready` takes the wrong level at once, or the wrong `rsp_err` is returned. A lost or misplaced PERR# pipeline stage shows two clocks after TRDY# in t5, or as PERR# in t4 or t6. A wrong status bit is visible from t3 and persists, because both bits are sticky. The bench compares every transaction against a reference model of the queue and the status bits that it keeps itself.

// File: rtl/dwpe_pkg.sv
package dwpe_pkg;
  typedef enum logic [1:0] {B_IDLE, B_DATA, B_PAR} bus_state_e;
  typedef enum logic [1:0] {Q_EMPTY, Q_PEND, Q_ISSUED, Q_DONE} q_state_e;
endpackage

// File: rtl/dwpe_parity.sv
module dwpe_parity #(
  parameter int W = 36
) (
  input  logic [W-1:0] bits,
  input  logic         par,
  output logic         err
);
  localparam int HALF = W / 2;
  logic lo_x, hi_x;
  assign lo_x = ^bits[HALF-1:0];
  assign hi_x = ^bits[W-1:HALF];
  assign err  = lo_x ^ hi_x ^ par;
endmodule

// File: rtl/dwpe_queue.sv
module dwpe_queue
  import dwpe_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq,
  input  logic          free,
  input  logic [DW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [BW-1:0] in_be,
  output logic          hit,
  output logic          occupied,
  output logic          done,
  output logic          status,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [DW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic [BW-1:0] req_be,
  input  logic          cpl_valid,
  output logic          cpl_ready,
  input  logic          cpl_err
);
  q_state_e      st;
  logic [DW-1:0] e_addr, e_data;
  logic [BW-1:0] e_be;
  logic          e_err;
  logic [BW-1:0] lane_eq;

  for (genvar i = 0; i < BW; i++) begin : g_lane
    assign lane_eq[i] = (e_data[8*i +: 8] == in_data[8*i +: 8]) && (e_be[i] == in_be[i]);
  end

  assign occupied  = (st != Q_EMPTY);
  assign done      = (st == Q_DONE);
  assign status    = e_err;
  assign hit       = occupied && (e_addr == in_addr) && (&lane_eq);
  assign req_valid = (st == Q_PEND);
  assign cpl_ready = (st == Q_ISSUED);
  assign req_addr  = e_addr;
  assign req_data  = e_data;
  assign req_be    = e_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= Q_EMPTY;
      e_addr <= '0;
      e_data <= '0;
      e_be   <= '0;
      e_err  <= 1'b0;
    end else begin
      unique case (st)
        Q_EMPTY: if (enq) begin
          st     <= Q_PEND;
          e_addr <= in_addr;
          e_data <= in_data;
          e_be   <= in_be;
          e_err  <= 1'b0;
        end
        Q_PEND:   if (req_valid && req_ready) st <= Q_ISSUED;
        Q_ISSUED: if (cpl_valid && cpl_ready) begin
          st    <= Q_DONE;
          e_err <= cpl_err;
        end
        Q_DONE:   if (free) st <= Q_EMPTY;
        default:  st <= Q_EMPTY;
      endcase
    end
  end

  // R4: an enqueue only lands in an empty slot
  p_enq_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enq |-> !occupied);
  // R9: freeing happens only after a completion was accepted
  p_free_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    free |-> done);
  // R7: request held stable under back-pressure
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_data) && $stable(req_be)));
  // R7: request and completion readiness never overlap
  p_req_cpl_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && cpl_ready));
endmodule

// File: rtl/dwpe_status.sv
module dwpe_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic mask,
  input  logic clr_dpe,
  input  logic clr_irq,
  output logic dpe,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpe <= 1'b0;
      irq <= 1'b0;
    end else begin
      dpe <= (dpe && !clr_dpe) || set;
      irq <= (irq && !clr_irq) || (set && !mask);
    end
  end

  // R5: sticky until cleared
  p_dpe_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dpe && !clr_dpe) |=> dpe);
  // R6: interrupt bit rises only on an unmasked detection
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set && !mask));
  // R6: interrupt bit never rises without the status bit
  p_irq_with_dpe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> dpe);
endmodule

// File: rtl/dwpe_top.sv
module dwpe_top
  import dwpe_pkg::*;
#(
  parameter int         DW         = 32,
  parameter int         BW         = DW / 8,
  parameter logic [3:0] CFG_WR_CMD = 4'b1011
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          perr_resp_en,
  input  logic          irq_mask,
  input  logic          addr_phase,
  input  logic          data_phase,
  input  logic [DW-1:0] ad,
  input  logic [BW-1:0] cbe,
  input  logic          par,
  output logic          trdy_n,
  output logic          stop_n,
  output logic          perr_n,
  output logic          rsp_err,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [DW-1:0] req_addr,
  output logic [DW-1:0] req_data,
  output logic [BW-1:0] req_be,
  input  logic          cpl_valid,
  output logic          cpl_ready,
  input  logic          cpl_err,
  output logic          dpe_sts,
  output logic          irq_sts,
  input  logic          clr_dpe,
  input  logic          clr_irq
);
  localparam int PW = DW + BW;

  bus_state_e    bst;
  logic [DW-1:0] cap_addr, cap_data;
  logic [BW-1:0] cap_be;
  logic          decide, par_err;
  logic          q_hit, q_occ, q_done, q_status;
  logic          fire_perr, do_enq, do_cmpl, do_stop;
  logic          perr_p1, perr_p2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bst      <= B_IDLE;
      cap_addr <= '0;
      cap_data <= '0;
      cap_be   <= '0;
    end else begin
      unique case (bst)
        B_IDLE: if (addr_phase && (cbe[3:0] == CFG_WR_CMD)) begin
          cap_addr <= ad;
          bst      <= B_DATA;
        end
        B_DATA: if (data_phase) begin
          cap_data <= ad;
          cap_be   <= cbe;
          bst      <= B_PAR;
        end
        B_PAR:   bst <= B_IDLE;
        default: bst <= B_IDLE;
      endcase
    end
  end

  assign decide = (bst == B_PAR);

  dwpe_parity #(.W(PW)) u_par (
    .bits ({cap_be, cap_data}),
    .par  (par),
    .err  (par_err)
  );

  always_comb begin
    fire_perr = decide && par_err && perr_resp_en;
    do_enq    = decide && !fire_perr && !q_occ;
    do_cmpl   = decide && !fire_perr && q_hit && q_done;
    do_stop   = decide && !fire_perr && !do_cmpl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trdy_n  <= 1'b1;
      stop_n  <= 1'b1;
      rsp_err <= 1'b0;
      perr_p1 <= 1'b0;
      perr_p2 <= 1'b0;
      perr_n  <= 1'b1;
    end else begin
      trdy_n  <= !(fire_perr || do_cmpl);
      stop_n  <= !do_stop;
      rsp_err <= do_cmpl && q_status;
      perr_p1 <= fire_perr;
      perr_p2 <= perr_p1;
      perr_n  <= !perr_p2;
    end
  end

  dwpe_queue #(.DW(DW), .BW(BW)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq       (do_enq),
    .free      (do_cmpl),
    .in_addr   (cap_addr),
    .in_data   (cap_data),
    .in_be     (cap_be),
    .hit       (q_hit),
    .occupied  (q_occ),
    .done      (q_done),
    .status    (q_status),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .req_be    (req_be),
    .cpl_valid (cpl_valid),
    .cpl_ready (cpl_ready),
    .cpl_err   (cpl_err)
  );

  dwpe_status u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (decide && par_err),
    .mask    (irq_mask),
    .clr_dpe (clr_dpe),
    .clr_irq (clr_irq),
    .dpe     (dpe_sts),
    .irq     (irq_sts)
  );

  // R1: the two handshake responses are exclusive
  p_resp_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!trdy_n && !stop_n));
  // R1: a response only follows the parity sampling cycle
  p_resp_after_par_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n || !stop_n) |-> $past(bst == B_PAR));
  // R3: PERR# two clocks after TRDY#
  p_perr_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(!trdy_n, 2));
  // R3: PERR# lasts one clock
  p_perr_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |=> perr_n);
  // R5: a PERR# implies a recorded detection
  p_perr_dpe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!perr_n && !$past(clr_dpe) && !$past(clr_dpe, 2)) |-> dpe_sts);
endmodule

// File: tb/sim_dwpe_top.sv
module sim_dwpe_top;
  localparam logic [3:0] CFG = 4'b1011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic perr_resp_en = 1'b0, irq_mask = 1'b0;
  logic addr_phase = 1'b0, data_phase = 1'b0, par = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic trdy_n, stop_n, perr_n, rsp_err;
  logic req_valid, req_ready = 1'b0, cpl_valid = 1'b0, cpl_ready, cpl_err = 1'b0;
  logic [31:0] req_addr, req_data;
  logic [3:0]  req_be;
  logic dpe_sts, irq_sts, clr_dpe = 1'b0, clr_irq = 1'b0;

  int checks = 0, errors = 0;
  bit finished = 0;

  int          m_st = 0;
  logic [31:0] m_addr, m_data;
  logic [3:0]  m_be;
  bit          m_err, m_dpe, m_irq;

  always #5 clk = ~clk;

  dwpe_top u0 (
    .clk(clk), .rst_n(rst_n), .perr_resp_en(perr_resp_en), .irq_mask(irq_mask),
    .addr_phase(addr_phase), .data_phase(data_phase), .ad(ad), .cbe(cbe), .par(par),
    .trdy_n(trdy_n), .stop_n(stop_n), .perr_n(perr_n), .rsp_err(rsp_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_be(req_be), .cpl_valid(cpl_valid),
    .cpl_ready(cpl_ready), .cpl_err(cpl_err), .dpe_sts(dpe_sts),
    .irq_sts(irq_sts), .clr_dpe(clr_dpe), .clr_irq(clr_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic even_par(input logic [31:0] d, input logic [3:0] b);
    return ^{b, d};
  endfunction

  task automatic check_status();
    chk(dpe_sts == m_dpe, m_dpe ? "R5" : "R2", 64'(dpe_sts), 64'(m_dpe));
    chk(irq_sts == m_irq, "R6", 64'(irq_sts), 64'(m_irq));
  endtask

  task automatic txn(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                     input logic [3:0] cmd, input bit bad);
    bit none, hit, fire, enq, cmpl, stp, exp_rsp;
    string tag;
    none = (cmd != CFG);
    hit  = (m_st != 0) && (a == m_addr) && (d == m_data) && (be == m_be);
    fire = !none && bad && perr_resp_en;
    enq  = !none && !fire && (m_st == 0);
    cmpl = !none && !fire && hit && (m_st == 3);
    stp  = !none && !fire && !cmpl;
    exp_rsp = cmpl && m_err;
    if (none) tag = "R12";
    else if (fire) tag = hit ? "R10" : "R3";
    else if (enq) tag = "R4";
    else if (cmpl) tag = "R9";
    else tag = hit ? "R8" : "R11";
    @(negedge clk);
    addr_phase = 1'b1; ad = a; cbe = cmd;
    @(negedge clk);
    addr_phase = 1'b0; data_phase = 1'b1; par = even_par(a, cmd); ad = d; cbe = be;
    @(negedge clk);
    chk(trdy_n && stop_n, "R1", {62'd0, trdy_n, stop_n}, 64'd3);
    data_phase = 1'b0; ad = '0; cbe = '0; par = even_par(d, be) ^ bad;
    @(negedge clk);
    par = 1'b0;
    if (enq) begin m_st = 1; m_addr = a; m_data = d; m_be = be; end
    if (cmpl) m_st = 0;
    if (!none && bad) begin m_dpe = 1; if (!irq_mask) m_irq = 1; end
    chk(trdy_n == !(fire || cmpl), tag, 64'(trdy_n), 64'(!(fire || cmpl)));
    chk(stop_n == !stp, tag, 64'(stop_n), 64'(!stp));
    if (fire || cmpl) chk(rsp_err == exp_rsp, tag, 64'(rsp_err), 64'(exp_rsp));
    chk(req_valid == (m_st == 1), tag, 64'(req_valid), 64'(m_st == 1));
    if (enq) chk({req_addr, req_data} == {a, d} && req_be == be, "R4",
                 {req_addr, req_data}, {a, d});
    chk(perr_n == 1'b1, tag, 64'(perr_n), 64'd1);
    @(negedge clk);
    chk(perr_n == 1'b1 && trdy_n && stop_n, tag, {61'd0, perr_n, trdy_n, stop_n}, 64'd7);
    @(negedge clk);
    chk(perr_n == !fire, tag, 64'(perr_n), 64'(!fire));
    @(negedge clk);
    chk(perr_n == 1'b1, "R3", 64'(perr_n), 64'd1);
    check_status();
  endtask

  task automatic deliver(input int hold);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(req_valid && req_addr == m_addr && req_data == m_data && req_be == m_be,
          "R7", {req_addr, req_data}, {m_addr, m_data});
    end
    @(negedge clk);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    m_st = 2;
    chk(!req_valid && cpl_ready, "R7", {62'd0, req_valid, cpl_ready}, 64'd1);
  endtask

  task automatic complete(input bit e);
    @(negedge clk);
    chk(cpl_ready == 1'b1, "R7", 64'(cpl_ready), 64'd1);
    cpl_valid = 1'b1; cpl_err = e;
    @(negedge clk);
    cpl_valid = 1'b0; cpl_err = 1'b0;
    m_st = 3; m_err = e;
    chk(cpl_ready == 1'b0, "R7", 64'(cpl_ready), 64'd0);
  endtask

  task automatic clear(input bit cd, input bit ci);
    @(negedge clk);
    clr_dpe = cd; clr_irq = ci;
    @(negedge clk);
    clr_dpe = 1'b0; clr_irq = 1'b0;
    if (cd) m_dpe = 0;
    if (ci) m_irq = 0;
    chk(dpe_sts == m_dpe, "R5", 64'(dpe_sts), 64'(m_dpe));
    chk(irq_sts == m_irq, "R6", 64'(irq_sts), 64'(m_irq));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trdy_n && stop_n && perr_n, "R1", {61'd0, trdy_n, stop_n, perr_n}, 64'd7);
    chk(!req_valid && !cpl_ready && !dpe_sts && !irq_sts, "R4",
        {60'd0, req_valid, cpl_ready, dpe_sts, irq_sts}, 64'd0);

    perr_resp_en = 1'b1; irq_mask = 1'b0;
    txn(32'h0000_1040, 32'h1234_5678, 4'hF, CFG, 0);
    deliver(2);
    txn(32'h0000_1040, 32'h1234_5678, 4'hF, CFG, 0);
    txn(32'h0000_2000, 32'hFFFF_0001, 4'h3, CFG, 0);
    complete(0);
    txn(32'h0000_1040, 32'h1234_5678, 4'hF, CFG, 1);
    txn(32'h0000_1040, 32'h1234_5678, 4'hF, CFG, 0);
    clear(1, 1);

    txn(32'h0000_3000, 32'h0000_0007, 4'h1, CFG, 1);
    clear(1, 1);

    perr_resp_en = 1'b0; irq_mask = 1'b1;
    txn(32'h0000_3000, 32'h0000_0007, 4'h1, CFG, 1);
    deliver(0);
    complete(1);
    txn(32'h0000_3000, 32'h0000_0007, 4'h1, CFG, 0);
    txn(32'h0000_4000, 32'hA5A5_A5A5, 4'hF, 4'b1010, 1);
    clear(1, 0);

    for (int it = 0; it < 400; it++) begin
      int op;
      logic [31:0] a, d;
      logic [3:0] be, cmd;
      op = int'($urandom % 10);
      perr_resp_en = 1'($urandom);
      irq_mask = 1'($urandom);
      if (op < 6) begin
        if (m_st != 0 && ($urandom % 2 == 0)) begin
          a = m_addr; d = m_data; be = m_be;
        end else begin
          a = $urandom; d = $urandom; be = 4'($urandom);
        end
        cmd = ($urandom % 8 == 0) ? 4'($urandom) : CFG;
        txn(a, d, be, cmd, ($urandom % 3) == 0);
      end else if (op == 6 || op == 7) begin
        if (m_st == 1) deliver(int'($urandom % 3));
        else if (m_st == 2) complete(1'($urandom));
      end else begin
        clear(1'($urandom), 1'($urandom));
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule